// File: doc/BRIEF.md
# AUX Request to I2C Byte-Master Bridge

This block accepts auxiliary-channel requests of the kind a display link carries and executes them. Each request names a command, an address and a byte count. Write payload arrives on a valid/ready byte stream, read payload leaves on a valid-qualified byte stream, and every request ends with one reply code.

Native requests walk a 20-bit byte-addressed register port one byte per access. I2C-over-AUX requests drive a byte-level I2C master through four operations: start (address plus direction), send byte, receive byte, and stop. Each operation is held until the master reports completion and an ack/nack status. The bridge remembers whether an I2C transaction is still open, along with the address and direction of the last middle-of-transaction (MOT) request. A following MOT request can therefore continue on the bus without a stop, or issue a stop and a fresh start when the target or the direction requires it.

Top module: `aux_i2c_bridge`

## Requirements
- R1: A native write (command 8) of N bytes (`req_len` = N-1, 1 to 16 bytes) stores the stream bytes at consecutive register addresses starting at `req_addr`, and replies code 0.
- R2: A native read (command 9) returns the register bytes in address order on `rd_valid`/`rd_data`. The address wraps modulo 2^20, and the reply is code 0.
- R3: When a native access reports `reg_err`, the bridge stops at that byte and replies code 1 (native NACK). The remaining write bytes of that request are drained from the stream and discarded.
- R4: A plain I2C write (command 0) does the following. If a transaction is open, it first issues a stop. It then issues a start and one send per byte, always closes with a stop, and replies code 0. Master operation codes are 0 start, 1 send, 2 receive and 3 stop. `m_go` and `m_op` hold steady until `m_done`.
- R5: A plain I2C read (command 1) issues a start with `m_rnw`=1 and one receive per byte. It emits each received byte in order and ends with a stop.
- R6: If a start is answered with `m_nack`, the reply is code 4 (I2C NACK) and no stop follows. Any write bytes of the request are drained.
- R7: A byte answered with `m_nack` ends the transfer. A stop follows, the reply is code 4, and the rest of the write bytes are drained. This applies to plain and MOT requests alike, and a MOT request's transaction is left closed.
- R8: A MOT write (command 4) issues a start when no transaction is open. When one is open, it issues a stop and a new start only if the address differs from the last MOT address or the last MOT request was a read. In every case it leaves the bus open without a stop.
- R9: A MOT read (command 5) on an open transaction issues a stop and a start only if the address changed. A change of direction alone does not restart.
- R10: Any other command code, write-status (2) included, replies code 1 one cycle after acceptance. It touches neither the register port, the I2C master, the write stream nor the open-transaction state.
- R11: Reset closes the open-transaction state and clears the last address and direction.
- R12: `req_ready` is high only when idle. Each accepted request produces exactly one single-cycle `rsp_done` pulse, and the bridge is ready again in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bridge idle, request taken when valid |
| req_cmd | input | 4 | Command code |
| req_addr | input | AW (20) | Register address or I2C target (low IW bits) |
| req_len | input | LW (4) | Byte count minus one |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte consumed |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| rsp_done | output | 1 | Reply pulse |
| rsp_code | output | 4 | Reply code, valid with rsp_done |
| reg_en | output | 1 | Register port access |
| reg_we | output | 1 | Register access is a write |
| reg_addr | output | AW (20) | Register byte address |
| reg_wdata | output | 8 | Register write byte |
| reg_rdata | input | 8 | Register read byte, same cycle |
| reg_err | input | 1 | Register access failed, same cycle |
| m_go | output | 1 | I2C master operation request |
| m_op | output | 2 | Operation: 0 start, 1 send, 2 receive, 3 stop |
| m_rnw | output | 1 | Direction for start |
| m_addr | output | IW (7) | I2C target address |
| m_wdata | output | 8 | Byte to send |
| m_done | input | 1 | Operation complete pulse |
| m_nack | input | 1 | Operation not acknowledged, with m_done |
| m_rdata | input | 8 | Received byte, with m_done |

## Verification
A request is taken on the edge where `req_valid` meets `req_ready`. Unsupported commands raise `rsp_done` in the very next cycle. For every other command, the reply comes one cycle after the final register access or the final `m_done`. A received byte appears on `rd_valid` in the same cycle as the `m_done` or register access that produced it. The bench drives inputs on falling edges and polls `rsp_done` on falling edges, so no result depends on a fixed latency. After each reply it compares the I2C start, stop, send and receive counts, the drained write stream and the captured read bytes against values computed from the request sequence.

// File: rtl/aux_i2c_bridge.sv
module aux_i2c_bridge #(
  parameter int AW = 20,
  parameter int LW = 4,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [3:0]    req_cmd,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [7:0]    wr_data,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  output logic          rsp_done,
  output logic [3:0]    rsp_code,
  output logic          reg_en,
  output logic          reg_we,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  input  logic [7:0]    reg_rdata,
  input  logic          reg_err,
  output logic          m_go,
  output logic [1:0]    m_op,
  output logic          m_rnw,
  output logic [IW-1:0] m_addr,
  output logic [7:0]    m_wdata,
  input  logic          m_done,
  input  logic          m_nack,
  input  logic [7:0]    m_rdata
);
  localparam logic [3:0] C_IWR = 4'd0, C_IRD = 4'd1, C_MWR = 4'd4, C_MRD = 4'd5;
  localparam logic [3:0] C_NWR = 4'd8, C_NRD = 4'd9;
  localparam logic [3:0] R_OK = 4'd0, R_NNAK = 4'd1, R_INAK = 4'd4;
  localparam logic [1:0] OP_START = 2'd0, OP_SEND = 2'd1, OP_RECV = 2'd2, OP_STOP = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_NAT, S_PRE, S_START, S_XFER, S_POST, S_DRAIN, S_REPLY} st_t;

  st_t          st;
  logic [3:0]   cmd, code;
  logic [AW-1:0] addr;
  logic [LW:0]  cnt;
  logic         open, last_rd;
  logic [IW-1:0] last_addr;

  wire is_wr     = ~cmd[0];
  wire is_mot    = cmd[2];
  wire last_byte = (cnt == 1);
  wire new_tgt   = (req_addr[IW-1:0] != last_addr);

  assign req_ready = (st == S_IDLE);
  assign rsp_done  = (st == S_REPLY);
  assign rsp_code  = code;

  assign reg_en    = (st == S_NAT) && (!is_wr || wr_valid);
  assign reg_we    = is_wr;
  assign reg_addr  = addr;
  assign reg_wdata = wr_data;

  assign m_go    = (st == S_PRE) || (st == S_START) || (st == S_POST) ||
                   ((st == S_XFER) && (!is_wr || wr_valid));
  assign m_rnw   = cmd[0];
  assign m_addr  = addr[IW-1:0];
  assign m_wdata = wr_data;

  always_comb begin
    case (st)
      S_START: m_op = OP_START;
      S_XFER:  m_op = is_wr ? OP_SEND : OP_RECV;
      default: m_op = OP_STOP;
    endcase
  end

  assign wr_ready = is_wr && ((st == S_NAT) || (st == S_DRAIN) || ((st == S_XFER) && m_done));
  assign rd_valid = !is_wr && (((st == S_NAT) && !reg_err) ||
                               ((st == S_XFER) && m_done && !m_nack));
  assign rd_data  = (st == S_NAT) ? reg_rdata : m_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cmd       <= '0;
      code      <= '0;
      addr      <= '0;
      cnt       <= '0;
      open      <= 1'b0;
      last_rd   <= 1'b0;
      last_addr <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          cmd  <= req_cmd;
          addr <= req_addr;
          cnt  <= {1'b0, req_len} + 1'b1;
          code <= R_OK;
          case (req_cmd)
            C_NWR, C_NRD: st <= S_NAT;
            C_IWR, C_IRD: st <= open ? S_PRE : S_START;
            C_MWR: st <= !open ? S_START : ((new_tgt || last_rd) ? S_PRE : S_XFER);
            C_MRD: st <= !open ? S_START : (new_tgt ? S_PRE : S_XFER);
            default: begin
              code <= R_NNAK;
              st   <= S_REPLY;
            end
          endcase
        end
        S_NAT: if (reg_en) begin
          cnt <= cnt - 1'b1;
          if (reg_err) begin
            code <= R_NNAK;
            st   <= (is_wr && !last_byte) ? S_DRAIN : S_REPLY;
          end else begin
            addr <= addr + 1'b1;
            if (last_byte) st <= S_REPLY;
          end
        end
        S_PRE: if (m_done) begin
          open <= 1'b0;
          st   <= S_START;
        end
        S_START: if (m_done) begin
          if (m_nack) begin
            code <= R_INAK;
            open <= 1'b0;
            st   <= is_wr ? S_DRAIN : S_REPLY;
          end else begin
            open <= 1'b1;
            st   <= S_XFER;
          end
        end
        S_XFER: if (m_done) begin
          cnt <= cnt - 1'b1;
          if (is_mot) begin
            last_addr <= addr[IW-1:0];
            last_rd   <= cmd[0];
          end
          if (m_nack) begin
            code <= R_INAK;
            st   <= S_POST;
          end else if (last_byte) begin
            st <= is_mot ? S_REPLY : S_POST;
          end
        end
        S_POST: if (m_done) begin
          open <= 1'b0;
          st   <= (is_wr && cnt != 0) ? S_DRAIN : S_REPLY;
        end
        S_DRAIN: if (wr_valid) begin
          cnt <= cnt - 1'b1;
          if (last_byte) st <= S_REPLY;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_i2c_bridge_chk.sv
module aux_i2c_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [3:0] req_cmd,
  input logic       rsp_done,
  input logic [3:0] rsp_code,
  input logic       reg_en,
  input logic       reg_we,
  input logic       reg_err,
  input logic       m_go,
  input logic [1:0] m_op,
  input logic       m_done
);
  wire known = (req_cmd == 4'd0) || (req_cmd == 4'd1) || (req_cmd == 4'd4) ||
               (req_cmd == 4'd5) || (req_cmd == 4'd8) || (req_cmd == 4'd9);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done && req_ready);

  // R12
  busy_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !req_ready);

  // R10
  unsupported_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !known) |=> rsp_done && rsp_code == 4'd1);

  // R3
  native_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_err && !reg_we) |=> rsp_done && rsp_code == 4'd1);

  // R4
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_go && !m_done) |=> m_go && $stable(m_op));

  // R10
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_go && reg_en));
endmodule

bind aux_i2c_bridge aux_i2c_bridge_chk u_chk (.*);

// File: tb/tb_aux_i2c_bridge.sv
`timescale 1ns/1ps
module tb_aux_i2c_bridge;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 1'b0, req_ready;
  logic [3:0] req_cmd = '0;
  logic [19:0] req_addr = '0;
  logic [3:0] req_len = '0;
  logic wr_valid, wr_ready;
  logic [7:0] wr_data;
  logic rd_valid;
  logic [7:0] rd_data;
  logic rsp_done;
  logic [3:0] rsp_code;
  logic reg_en, reg_we, reg_err;
  logic [19:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic m_go, m_rnw, m_done, m_nack;
  logic [1:0] m_op;
  logic [6:0] m_addr;
  logic [7:0] m_wdata, m_rdata;

  aux_i2c_bridge dut (.*);

  int checks = 0, errors = 0;
  logic [7:0] wq [256];
  int wn = 0, wptr = 0;
  logic [7:0] rbuf [256];
  int rn = 0;
  logic [7:0] mem [256];
  logic [7:0] sbuf [256];
  int n_start = 0, n_stop = 0, n_send = 0, n_recv = 0, n_reg = 0;
  int fail_at = -1;

  assign wr_valid  = (wptr < wn);
  assign wr_data   = wq[wptr & 255];
  assign reg_rdata = mem[reg_addr[7:0]];
  assign reg_err   = (reg_addr[7:0] == 8'hEE);

  always @(posedge clk) begin
    if (wr_valid && wr_ready) wptr <= wptr + 1;
    if (rd_valid) begin rbuf[rn & 255] <= rd_data; rn <= rn + 1; end
    if (reg_en) begin
      n_reg <= n_reg + 1;
      if (reg_we && !reg_err) mem[reg_addr[7:0]] <= reg_wdata;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) m_done <= 1'b0;
    else if (m_go && !m_done) begin
      m_done <= 1'b1;
      case (m_op)
        2'd0: begin n_start <= n_start + 1; m_nack <= !(m_addr == 7'h50 || m_addr == 7'h51); end
        2'd1: begin sbuf[n_send & 255] <= m_wdata; n_send <= n_send + 1; m_nack <= (m_wdata == 8'hFF); end
        2'd2: begin m_rdata <= 8'hA0 + 8'(n_recv); m_nack <= (n_recv == fail_at); n_recv <= n_recv + 1; end
        default: begin n_stop <= n_stop + 1; m_nack <= 1'b0; end
      endcase
    end else m_done <= 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    wq[wn & 255] = b;
    wn++;
  endtask

  int s_st, s_sp, s_sd, s_rc, s_rn, s_rg;
  logic [3:0] code;

  task automatic req(input logic [3:0] c, input logic [19:0] a, input int n);
    s_st = n_start; s_sp = n_stop; s_sd = n_send; s_rc = n_recv; s_rn = rn; s_rg = n_reg;
    @(negedge clk);
    req_cmd = c; req_addr = a; req_len = 4'(n - 1); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_done) @(negedge clk);
    code = rsp_code;
    @(negedge clk);
  endtask

  task automatic ops(input string tag, input int st, input int sp);
    chk(n_start - s_st == st, {tag, " starts"}, n_start - s_st, st);
    chk(n_stop - s_sp == sp, {tag, " stops"}, n_stop - s_sp, sp);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(req_ready && !rsp_done && !m_go && !reg_en, "R12 reset idle", req_ready, 1);

    // R1 native write, R2 read back
    push(8'h11); push(8'h22); push(8'h33); push(8'h44);
    req(4'd8, 20'h00010, 4);
    chk(code == 0, "R1 write reply", code, 0);
    chk(n_reg - s_rg == 4, "R1 accesses", n_reg - s_rg, 4);
    req(4'd9, 20'h00010, 4);
    chk(code == 0, "R2 read reply", code, 0);
    chk(rn - s_rn == 4, "R2 read count", rn - s_rn, 4);
    for (int i = 0; i < 4; i++)
      chk(rbuf[(s_rn + i) & 255] == 8'(8'h11 * (i + 1)), "R1 R2 data", rbuf[(s_rn + i) & 255], 8'h11 * (i + 1));

    // R2 wrap
    push(8'h5A); push(8'hA5);
    req(4'd8, 20'hFFFFF, 2);
    req(4'd9, 20'h00000, 1);
    chk(rbuf[s_rn & 255] == 8'hA5, "R2 wrap", rbuf[s_rn & 255], 8'hA5);
    req(4'd9, 20'hFFFFF, 2);
    chk(rbuf[s_rn & 255] == 8'h5A && rbuf[(s_rn + 1) & 255] == 8'hA5, "R2 wrap read", rbuf[s_rn & 255], 8'h5A);

    // R3 native failure
    push(8'h01); push(8'h02);
    req(4'd8, 20'h000EC, 2);
    req(4'd9, 20'h000EC, 4);
    chk(code == 1, "R3 read fail reply", code, 1);
    chk(rn - s_rn == 2, "R3 read stops", rn - s_rn, 2);
    for (int i = 0; i < 4; i++) push(8'h77);
    req(4'd8, 20'h000EC, 4);
    chk(code == 1, "R3 write fail reply", code, 1);
    chk(wptr == wn, "R3 drained", wptr, wn);
    chk(n_reg - s_rg == 3, "R3 write stops", n_reg - s_rg, 3);

    // R4 plain write
    push(8'h10); push(8'h20); push(8'h30);
    req(4'd0, 20'h00050, 3);
    chk(code == 0, "R4 reply", code, 0);
    ops("R4", 1, 1);
    chk(n_send - s_sd == 3 && sbuf[(s_sd + 2) & 255] == 8'h30, "R4 sent", n_send - s_sd, 3);

    // R5 plain read
    req(4'd1, 20'h00050, 3);
    chk(code == 0, "R5 reply", code, 0);
    ops("R5", 1, 1);
    for (int i = 0; i < 3; i++)
      chk(rbuf[(s_rn + i) & 255] == 8'(8'hA0 + s_rc + i), "R5 data", rbuf[(s_rn + i) & 255], 8'(8'hA0 + s_rc + i));

    // R6 start nack
    push(8'h01); push(8'h02);
    req(4'd0, 20'h00033, 2);
    chk(code == 4, "R6 reply", code, 4);
    ops("R6", 1, 0);
    chk(n_send == s_sd && wptr == wn, "R6 drained", wptr, wn);

    // R7 byte failures
    push(8'h01); push(8'hFF); push(8'h02);
    req(4'd0, 20'h00050, 3);
    chk(code == 4, "R7 write reply", code, 4);
    ops("R7 write", 1, 1);
    chk(n_send - s_sd == 2 && wptr == wn, "R7 write drained", n_send - s_sd, 2);
    fail_at = n_recv + 1;
    req(4'd1, 20'h00050, 3);
    fail_at = -1;
    chk(code == 4 && rn - s_rn == 1, "R7 read reply", code, 4);
    ops("R7 read", 1, 1);

    // R8 / R9 MOT sequences
    push(8'h01);
    req(4'd4, 20'h00050, 1); ops("R8 first", 1, 0);
    chk(code == 0, "R8 reply", code, 0);
    push(8'h02);
    req(4'd4, 20'h00050, 1); ops("R8 continue", 0, 0);
    req(4'd5, 20'h00050, 2); ops("R9 direction only", 0, 0);
    chk(code == 0 && rn - s_rn == 2, "R9 data", rn - s_rn, 2);
    push(8'h03);
    req(4'd4, 20'h00050, 1); ops("R8 after read", 1, 1);
    push(8'h04);
    req(4'd4, 20'h00051, 1); ops("R8 new addr", 1, 1);
    req(4'd5, 20'h00051, 1); ops("R9 same addr", 0, 0);
    req(4'd5, 20'h00050, 1); ops("R9 new addr", 1, 1);
    push(8'h05);
    req(4'd0, 20'h00050, 1); ops("R4 closes open", 1, 2);

    // R7 MOT failure closes
    push(8'hFF);
    req(4'd4, 20'h00050, 1);
    chk(code == 4, "R7 mot reply", code, 4);
    ops("R7 mot", 1, 1);
    push(8'h06);
    req(4'd4, 20'h00050, 1); ops("R7 reopen", 1, 0);

    // R10 unsupported
    push(8'h07);
    for (int c = 0; c < 16; c++) begin
      if (c == 0 || c == 1 || c == 4 || c == 5 || c == 8 || c == 9) continue;
      req(4'(c), 20'h00050, 1);
      chk(code == 1, "R10 reply", code, 1);
      ops("R10", 0, 0);
      chk(n_reg == s_rg && n_send == s_sd && wptr == wn - 1, "R10 no effect", wptr, wn - 1);
    end
    req(4'd4, 20'h00050, 1); ops("R10 state kept", 0, 0);

    // R11 reset clears open state
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    push(8'h08);
    req(4'd4, 20'h00050, 1); ops("R11", 1, 0);
    chk(code == 0 && req_ready, "R11 R12 ready", req_ready, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule